// File: doc/BRIEF.md
# SPI Command Sequencer Engine

This block is an SPI master that runs a program instead of being set up through registers. Each 16-bit word taken from the command stream is one instruction. An instruction can move a counted run of bytes, drive the eight active-low chip-select lines and then wait, load the clock divider or the mode configuration, idle for a timed number of SCLK periods, or emit a sync marker. Software writes a whole SPI message as one sequence of instructions and ends it with a sync marker. When the marker comes back, every instruction before it has finished.

Transmit bytes come from a valid/ready source and received bytes go to a valid/ready sink. Both are 8 bits wide and shifted MSB first. If a needed transmit byte is missing, or the sink will not take a finished byte, the engine stops with SCLK parked. It does not drop or invent data.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, cs_n is 0xFF, sclk and sdo are 0, sdo_oe is 1, rx_valid and sync_valid are 0, and cmd_ready is 1.
- R2: A command word holds the opcode in bits 15:12, a 4-bit argument A in bits 11:8 and an 8-bit argument B in bits 7:0. Opcode 1 drives cs_n to B on the cycle after it is accepted. The next command is then accepted 2*A*(divider+1)+1 cycles after this one. cs_n changes at no other time.
- R3: Opcode 0 moves B+1 bytes, MSB first. A bit 0 takes each sdo byte from the transmit source, and A bit 1 delivers each sampled byte to the receive sink.
- R4: Every SCLK half-period inside a byte lasts divider+1 clock cycles. Opcode 2 with A=0 loads the divider from B.
- R5: Opcode 2 with A=1 loads the configuration from B. Bit 0 is clock phase: 0 samples on the leading edge and 1 samples on the trailing edge. Bit 1 is the idle SCLK level. Bit 2 selects 3-wire mode.
- R6: In a transfer without the write flag, sdo stays 0 and no transmit byte is consumed. Without the read flag, no byte is offered to the receive sink.
- R7: While a write transfer waits for a transmit byte, sclk does not toggle.
- R8: While a finished received byte is refused by the sink, rx_valid stays high, rx_data stays stable and sclk does not toggle.
- R9: Opcode 3 with A=1 holds sclk idle. The next command is accepted 2*(B+1)*(divider+1)+1 cycles later.
- R10: Opcode 3 with A=0 raises sync_valid for one cycle with sync_id=B, the cycle after it is accepted. All earlier transfers have completed by then.
- R11: In 3-wire mode, sdo_oe is high only during a transfer that has the write flag. In 4-wire mode it is always high. Whenever sdo_oe is low, sdo is 0.
- R12: Reset leaves the divider at 0 and the configuration at 0, which is mode 0 with 4-wire output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word available |
| cmd_ready | output | 1 | Engine accepts a command this cycle |
| cmd_data | input | 16 | Command word |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes the transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte offered |
| rx_ready | input | 1 | Sink takes the received byte |
| rx_data | output | 8 | Received byte |
| sync_valid | output | 1 | One-cycle sync marker strobe |
| sync_id | output | 8 | Identifier of the sync marker |
| sclk | output | 1 | SPI clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
A corrupted divider or phase counter appears on the very next SCLK edge as a half-period of the wrong length. A wrong bit counter or shift register shows up as a wrong byte on sdo or rx_data once that byte completes. A stuck state machine shows up as a wrong gap between accepted commands, or as a sync marker that arrives while bytes are still outstanding. The bench decodes every SCLK edge from the pins and keeps its own queues of expected bytes, chip-select patterns and command gaps. It therefore sees such faults within one byte time.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int BYTE_W = 8;
    localparam int CS_W   = 8;
    localparam int WAIT_W = BYTE_W + 1;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_CSWAIT,
        ST_SLEEP,
        ST_LOAD,
        ST_BIT,
        ST_PUSH
    } state_e;

    typedef struct packed {
        logic three_wire;
        logic cpol;
        logic cpha;
    } cfg_t;
endpackage

// File: rtl/spi_seq_decode.sv
module spi_seq_decode (
    input  logic [15:0] word,
    output logic        is_xfer,
    output logic        is_cs,
    output logic        is_wreg,
    output logic        is_sleep,
    output logic        is_sync,
    output logic [3:0]  arg_a,
    output logic [7:0]  arg_b
);
    logic [3:0] opc;

    always_comb begin
        opc      = word[15:12];
        arg_a    = word[11:8];
        arg_b    = word[7:0];
        is_xfer  = (opc == 4'd0);
        is_cs    = (opc == 4'd1);
        is_wreg  = (opc == 4'd2);
        is_sleep = (opc == 4'd3) && (arg_a == 4'd1);
        is_sync  = (opc == 4'd3) && (arg_a == 4'd0);
    end
endmodule

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (!en || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [15:0] cmd_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    input  logic [7:0]  tx_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic [7:0]  rx_data,
    output logic        sync_valid,
    output logic [7:0]  sync_id,
    output logic        sclk,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic        sdi,
    output logic [7:0]  cs_n
);
    localparam int BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        state_e              st;
        cfg_t                cfg;
        logic [BYTE_W-1:0]   div;
        logic [CS_W-1:0]     cs;
        logic                phase;
        logic [BIT_W-1:0]    bitn;
        logic [BYTE_W-1:0]   left;
        logic                wr;
        logic                rd;
        logic [BYTE_W-1:0]   txs;
        logic [BYTE_W-1:0]   rxs;
        logic                sdo;
        logic [WAIT_W-1:0]   wcnt;
        logic                sync_v;
        logic [BYTE_W-1:0]   sync_id;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick, tick_en, last_bit;
    logic  is_xfer, is_cs, is_wreg, is_sleep, is_sync;
    logic [3:0] arg_a;
    logic [7:0] arg_b;

    spi_seq_decode u_dec (
        .word    (cmd_data),
        .is_xfer (is_xfer),
        .is_cs   (is_cs),
        .is_wreg (is_wreg),
        .is_sleep(is_sleep),
        .is_sync (is_sync),
        .arg_a   (arg_a),
        .arg_b   (arg_b)
    );

    assign tick_en = (r_q.st == ST_BIT) || (r_q.st == ST_SLEEP) || (r_q.st == ST_CSWAIT);

    spi_seq_tick #(.DIV_W(BYTE_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .div  (r_q.div),
        .tick (tick)
    );

    assign last_bit = (r_q.bitn == BIT_W'(BYTE_W - 1));

    always_comb begin
        r_d        = r_q;
        r_d.sync_v = 1'b0;
        unique case (r_q.st)
            ST_FETCH: begin
                if (cmd_valid) begin
                    if (is_xfer) begin
                        r_d.wr   = arg_a[0];
                        r_d.rd   = arg_a[1];
                        r_d.left = arg_b;
                        r_d.st   = ST_LOAD;
                    end else if (is_cs) begin
                        r_d.cs = arg_b;
                        if (arg_a != 4'd0) begin
                            r_d.wcnt = WAIT_W'({arg_a, 1'b0}) - 1'b1;
                            r_d.st   = ST_CSWAIT;
                        end
                    end else if (is_wreg) begin
                        if (arg_a == 4'd0) r_d.div = arg_b;
                        if (arg_a == 4'd1) r_d.cfg = arg_b[2:0];
                    end else if (is_sleep) begin
                        r_d.wcnt = {arg_b, 1'b1};
                        r_d.st   = ST_SLEEP;
                    end else if (is_sync) begin
                        r_d.sync_v  = 1'b1;
                        r_d.sync_id = arg_b;
                    end
                end
            end
            ST_CSWAIT, ST_SLEEP: begin
                if (tick) begin
                    if (r_q.wcnt == '0) r_d.st = ST_FETCH;
                    else                r_d.wcnt = r_q.wcnt - 1'b1;
                end
            end
            ST_LOAD: begin
                if (!r_q.wr || tx_valid) begin
                    r_d.txs   = r_q.wr ? tx_data : '0;
                    r_d.bitn  = '0;
                    r_d.phase = 1'b0;
                    if (!r_q.cfg.cpha) r_d.sdo = r_q.wr ? tx_data[BYTE_W-1] : 1'b0;
                    r_d.st    = ST_BIT;
                end
            end
            ST_BIT: begin
                if (tick) begin
                    if (!r_q.phase) begin
                        r_d.phase = 1'b1;
                        if (r_q.cfg.cpha) begin
                            r_d.sdo = r_q.txs[BYTE_W-1];
                            r_d.txs = {r_q.txs[BYTE_W-2:0], 1'b0};
                        end else begin
                            r_d.rxs = {r_q.rxs[BYTE_W-2:0], sdi};
                        end
                    end else begin
                        r_d.phase = 1'b0;
                        r_d.bitn  = r_q.bitn + 1'b1;
                        if (r_q.cfg.cpha) begin
                            r_d.rxs = {r_q.rxs[BYTE_W-2:0], sdi};
                            if (last_bit) r_d.sdo = 1'b0;
                        end else begin
                            r_d.sdo = r_q.txs[BYTE_W-2];
                            r_d.txs = {r_q.txs[BYTE_W-2:0], 1'b0};
                        end
                        if (last_bit) begin
                            if (r_q.rd)                 r_d.st = ST_PUSH;
                            else if (r_q.left == '0)    r_d.st = ST_FETCH;
                            else begin
                                r_d.left = r_q.left - 1'b1;
                                r_d.st   = ST_LOAD;
                            end
                        end
                    end
                end
            end
            ST_PUSH: begin
                if (rx_ready) begin
                    if (r_q.left == '0) r_d.st = ST_FETCH;
                    else begin
                        r_d.left = r_q.left - 1'b1;
                        r_d.st   = ST_LOAD;
                    end
                end
            end
            default: r_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_FETCH;
            r_q.cs      <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready  = (r_q.st == ST_FETCH);
    assign tx_ready   = (r_q.st == ST_LOAD) && r_q.wr;
    assign rx_valid   = (r_q.st == ST_PUSH);
    assign rx_data    = r_q.rxs;
    assign sync_valid = r_q.sync_v;
    assign sync_id    = r_q.sync_id;
    assign sclk       = r_q.cfg.cpol ^ r_q.phase;
    assign sdo        = r_q.sdo;
    assign cs_n       = r_q.cs;
    assign sdo_oe     = !r_q.cfg.three_wire ||
                        (r_q.wr && ((r_q.st == ST_LOAD) || (r_q.st == ST_BIT) || (r_q.st == ST_PUSH)));
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [15:0] cmd_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [7:0]  rx_data,
    input logic        sync_valid,
    input logic [7:0]  sync_id,
    input logic        sclk,
    input logic        sdo,
    input logic        sdo_oe,
    input logic [7:0]  cs_n
);
    assert_cs_only_by_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> $past(cmd_valid && cmd_ready && cmd_data[15:12] == 4'h1));

    assert_tx_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> $stable(sclk));

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(sclk)));

    assert_sync_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |-> ($past(cmd_valid && cmd_ready && cmd_data[15:8] == 8'h30)
                        && sync_id == $past(cmd_data[7:0])));

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
endmodule

bind spi_cmd_seq spi_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .sync_valid(sync_valid),
    .sync_id   (sync_id),
    .sclk      (sclk),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .cs_n      (cs_n)
);

// File: tb/test_spi_cmd_seq.sv
module test_spi_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [15:0] cmd_data = '0;
    logic        tx_valid = 1'b0, tx_ready;
    logic [7:0]  tx_data = '0;
    logic        rx_valid, rx_ready = 1'b1;
    logic [7:0]  rx_data;
    logic        sync_valid;
    logic [7:0]  sync_id;
    logic        sclk, sdo, sdo_oe;
    logic        sdi = 1'b0;
    logic [7:0]  cs_n;

    always #2 clk = ~clk;

    spi_cmd_seq i_spi_cmd_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sync_valid(sync_valid), .sync_id(sync_id),
        .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .cs_n(cs_n)
    );

    int total = 0, bad = 0, cyc = 0, sync_cnt = 0, lead_total = 0;
    bit done = 0;

    logic [15:0] cmd_q[$];
    int          gap_q[$];
    string       gtag_q[$];
    logic [7:0]  tx_q[$], miso_q[$], exp_mosi[$], exp_cs[$], exp_rx[$];
    logic [7:0]  exp_sync[$], exp_sync_cs[$];
    bit          exp_oe[$];

    bit m_cpol = 0, m_cpha = 0;
    int m_div = 0;
    bit tx_en = 1, rx_hold = 0;
    string ptag = "R12";

    bit cmd_pend = 0, tx_pend = 0;
    int prev_gap = -1, prev_fc = 0;
    string prev_tag = "";
    bit sclk_prev = 0, sdo_prev = 0, oe_prev = 1, seen_lead = 0;
    int lead_c = 0, sidx = 0;
    logic [7:0] mbyte = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic sample_bit();
        logic [7:0] em, ec;
        bit eo;
        mbyte = {mbyte[6:0], sdo_prev};
        sidx++;
        if (sidx == 8) begin
            sidx = 0;
            if (miso_q.size() > 0) void'(miso_q.pop_front());
            if (exp_mosi.size() == 0) chk(0, {ptag, " unexpected byte"}, mbyte, 0);
            else begin
                em = exp_mosi.pop_front();
                ec = exp_cs.pop_front();
                eo = exp_oe.pop_front();
                chk(mbyte == em, {ptag, " R3 sdo byte"}, mbyte, em);
                chk(cs_n == ec, "R2 cs_n during byte", cs_n, ec);
                chk(oe_prev == eo, "R11 sdo_oe during byte", oe_prev, eo);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            // command source
            if (cmd_pend) void'(cmd_q.pop_front());
            cmd_valid = (cmd_q.size() > 0);
            cmd_data  = cmd_valid ? cmd_q[0] : 16'h0;
            cmd_pend  = cmd_valid && cmd_ready;
            if (cmd_pend) begin
                if (prev_gap >= 0) chk(cyc - prev_fc == prev_gap, prev_tag, cyc - prev_fc, prev_gap);
                prev_gap = gap_q.pop_front();
                prev_tag = gtag_q.pop_front();
                prev_fc  = cyc;
            end
            // transmit source
            if (tx_pend) void'(tx_q.pop_front());
            tx_valid = tx_en && (tx_q.size() > 0);
            tx_data  = tx_valid ? tx_q[0] : 8'h0;
            tx_pend  = tx_valid && tx_ready;
            // receive sink
            rx_ready = !rx_hold;
            if (rx_valid && rx_ready) begin
                if (exp_rx.size() == 0) chk(0, {ptag, " R6 unexpected rx byte"}, rx_data, 0);
                else begin
                    logic [7:0] er;
                    er = exp_rx.pop_front();
                    chk(rx_data == er, {ptag, " R3 rx byte"}, rx_data, er);
                end
            end
            // sync markers
            if (sync_valid) begin
                logic [7:0] es, esc;
                es  = exp_sync.pop_front();
                esc = exp_sync_cs.pop_front();
                chk(sync_id == es, "R10 sync id", sync_id, es);
                chk(exp_mosi.size() == 0 && exp_rx.size() == 0, "R10 sync after all bytes",
                    exp_mosi.size() + exp_rx.size(), 0);
                chk(cs_n == esc, "R2 cs_n at sync", cs_n, esc);
                sync_cnt++;
            end
            // SPI slave model
            if (sclk != sclk_prev) begin
                if (sclk != m_cpol) begin
                    lead_total++;
                    lead_c    = cyc;
                    seen_lead = 1;
                    if (!m_cpha) sample_bit();
                end else if (seen_lead) begin
                    seen_lead = 0;
                    chk(cyc - lead_c == m_div + 1, "R4 half period", cyc - lead_c, m_div + 1);
                    if (m_cpha) sample_bit();
                end
            end
            sclk_prev = sclk;
            sdo_prev  = sdo;
            oe_prev   = sdo_oe;
            sdi       = (miso_q.size() > 0) ? miso_q[0][7 - sidx] : 1'b0;
        end
    end

    task automatic q_cmd(input logic [3:0] op, input logic [3:0] a, input logic [7:0] b,
                         input int gap, input string tag);
        cmd_q.push_back({op, a, b});
        gap_q.push_back(gap);
        gtag_q.push_back(tag);
    endtask

    task automatic q_byte(input logic [7:0] mo, input logic [7:0] mi, input bit wr, input bit rd,
                          input logic [7:0] cs, input bit oe);
        if (wr) tx_q.push_back(mo);
        miso_q.push_back(mi);
        exp_mosi.push_back(wr ? mo : 8'h00);
        if (rd) exp_rx.push_back(mi);
        exp_cs.push_back(cs);
        exp_oe.push_back(oe);
    endtask

    task automatic q_sync(input logic [7:0] id);
        q_cmd(4'h3, 4'h0, id, -1, "");
        exp_sync.push_back(id);
        exp_sync_cs.push_back(8'hFF);
    endtask

    task automatic q_mode(input bit cpol, input bit cpha, input bit tw, input int div);
        m_cpol = cpol; m_cpha = cpha; m_div = div;
        q_cmd(4'h2, 4'h1, {5'd0, tw, cpol, cpha}, -1, "");
        q_cmd(4'h2, 4'h0, 8'(div), -1, "");
    endtask

    task automatic wait_sync(input int n);
        while (sync_cnt < n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        finish_up();
    end

    initial begin
        int snap, ssnap;
        repeat (3) @(negedge clk);
        chk(cs_n == 8'hFF && sclk == 0 && sdo == 0 && sdo_oe == 1, "R1 reset pins",
            {cs_n, sclk, sdo, sdo_oe}, {8'hFF, 3'b001});
        chk(!rx_valid && !sync_valid && cmd_ready, "R1 reset handshakes",
            {rx_valid, sync_valid, cmd_ready}, 3'b001);
        rst_n = 1'b1;

        // R12: defaults, divider 0, mode 0
        ptag = "R12";
        q_cmd(4'h1, 4'h1, 8'hFE, 3, "R12 cs delay with reset divider");
        q_cmd(4'h0, 4'h3, 8'h00, -1, "");
        q_byte(8'h96, 8'h69, 1, 1, 8'hFE, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h01);
        wait_sync(1);

        // mode 0, divider 1, three bytes both ways
        ptag = "R3";
        q_mode(0, 0, 0, 1);
        q_cmd(4'h1, 4'h2, 8'hFE, 9, "R2 cs delay");
        q_cmd(4'h0, 4'h3, 8'h02, -1, "");
        q_byte(8'hA5, 8'h5A, 1, 1, 8'hFE, 1);
        q_byte(8'h3C, 8'hC3, 1, 1, 8'hFE, 1);
        q_byte(8'hF0, 8'h0F, 1, 1, 8'hFE, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, 1, "R2 cs no delay");
        q_sync(8'h11);
        wait_sync(2);

        // mode 3, divider 2, write-only then read-only, sleep
        ptag = "R5";
        q_mode(1, 1, 0, 2);
        q_cmd(4'h1, 4'h0, 8'h7F, -1, "");
        q_cmd(4'h0, 4'h1, 8'h01, -1, "");
        q_byte(8'h81, 8'h00, 1, 0, 8'h7F, 1);
        q_byte(8'h7E, 8'h00, 1, 0, 8'h7F, 1);
        q_cmd(4'h0, 4'h2, 8'h00, -1, "");
        q_byte(8'h00, 8'h96, 0, 1, 8'h7F, 1);
        q_cmd(4'h3, 4'h1, 8'h02, 19, "R9 sleep length");
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h22);
        wait_sync(3);
        chk(sclk == 1'b1, "R5 idle level cpol=1", sclk, 1);

        // mode 1, divider 0
        q_mode(0, 1, 0, 0);
        q_cmd(4'h1, 4'h0, 8'hFD, -1, "");
        q_cmd(4'h0, 4'h3, 8'h00, -1, "");
        q_byte(8'hC3, 8'h69, 1, 1, 8'hFD, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h33);
        wait_sync(4);

        // mode 2, divider 3
        q_mode(1, 0, 0, 3);
        q_cmd(4'h1, 4'h0, 8'hFB, -1, "");
        q_cmd(4'h0, 4'h3, 8'h00, -1, "");
        q_byte(8'h1E, 8'hE1, 1, 1, 8'hFB, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h44);
        wait_sync(5);

        // R6: read-only transfer leaves a waiting transmit byte alone
        ptag = "R6";
        q_mode(0, 0, 0, 0);
        tx_q.push_back(8'hEE);
        q_cmd(4'h1, 4'h0, 8'hF7, -1, "");
        q_cmd(4'h0, 4'h2, 8'h00, -1, "");
        q_byte(8'h00, 8'h5C, 0, 1, 8'hF7, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h55);
        wait_sync(6);
        chk(tx_q.size() == 1, "R6 transmit byte not consumed", tx_q.size(), 1);
        tx_q.delete();
        repeat (2) @(negedge clk);

        // R7: missing transmit byte stalls SCLK
        ptag = "R7";
        tx_en = 0;
        q_cmd(4'h1, 4'h0, 8'hEF, -1, "");
        q_cmd(4'h0, 4'h1, 8'h00, -1, "");
        q_byte(8'hAA, 8'h00, 1, 0, 8'hEF, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h66);
        snap = lead_total; ssnap = sync_cnt;
        repeat (60) @(negedge clk);
        chk(lead_total == snap, "R7 no SCLK edge while starved", lead_total - snap, 0);
        chk(sync_cnt == ssnap, "R7 no sync while starved", sync_cnt - ssnap, 0);
        tx_en = 1;
        wait_sync(7);

        // R8: refused receive byte stalls SCLK
        ptag = "R8";
        rx_hold = 1;
        q_cmd(4'h1, 4'h0, 8'hDF, -1, "");
        q_cmd(4'h0, 4'h2, 8'h01, -1, "");
        q_byte(8'h00, 8'h12, 0, 1, 8'hDF, 1);
        q_byte(8'h00, 8'h34, 0, 1, 8'hDF, 1);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h77);
        snap = lead_total;
        repeat (100) @(negedge clk);
        chk(lead_total - snap == 8, "R8 only first byte clocked", lead_total - snap, 8);
        chk(rx_valid && rx_data == 8'h12, "R8 byte held", {rx_valid, rx_data}, 9'h112);
        rx_hold = 0;
        wait_sync(8);

        // R11: 3-wire output enable
        ptag = "R11";
        q_mode(0, 0, 1, 1);
        q_cmd(4'h1, 4'h0, 8'hBF, -1, "");
        q_cmd(4'h0, 4'h1, 8'h00, -1, "");
        q_byte(8'h3C, 8'h00, 1, 0, 8'hBF, 1);
        q_cmd(4'h0, 4'h2, 8'h00, -1, "");
        q_byte(8'h00, 8'hA6, 0, 1, 8'hBF, 0);
        q_cmd(4'h1, 4'h0, 8'hFF, -1, "");
        q_sync(8'h88);
        wait_sync(9);
        repeat (2) @(negedge clk);
        chk(sdo_oe == 1'b0, "R11 idle 3-wire output off", sdo_oe, 0);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule